// File: doc/BRIEF.md
# Half-Duplex Congestion Back-Pressure Controller

This block protects a half-duplex receive port from losing frames when the shared output queue fills up. It compares the number of queue entries in use against a threshold captured during reset. When the queue is congested and a new frame appears on the port's carrier sense, it raises a jam request. The transmit side uses this request to force a collision, so the remote station backs off and retries later.

A strap, also captured during reset, can turn back pressure off. With back pressure off, the block never jams. Instead, it flags each new frame for dropping if no free buffer is available when the frame starts. In full-duplex operation the jam request stays quiet, because collisions have no meaning there. The MAC transmit path and the buffer memory sit outside this block.

Top module: `bp_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `jamReq` and `dropFlag` are both 0.
- R2: With back pressure enabled and half duplex, a rising `carrierSense` sampled at a clock edge raises `jamReq` after that same edge if `queueUsed >= threshold`, where the threshold is an unsigned compare and equality counts as congested. Otherwise `jamReq` stays 0.
- R3: With carrier held, one jam lasts exactly JAM_LEN clock cycles (default 32, one cycle per bit time).
- R4: At most one jam is issued per frame. After the jam ends, the frame gets no further jam while carrier stays high, even if `queueUsed` changes.
- R5: When `carrierSense` is sampled low, `jamReq` is 0 after that edge.
- R6: With `fullDuplex` high, no jam starts. If `fullDuplex` rises during a jam, `jamReq` is 0 after the next edge.
- R7: `bpDisableStrap` is sampled while reset is held. A value of 1 disables jamming for the whole run.
- R8: With back pressure disabled, a frame whose first carrier cycle sees `freeAvail` = 0 sets `dropFlag` after that edge. The flag holds until carrier is sampled low.
- R9: `dropFlag` is never set while back pressure is enabled, nor when `freeAvail` = 1 at frame start.
- R10: `cfgThreshold` is sampled only while reset is held. Changing it afterwards has no effect on the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per bit time |
| rst_n | input | 1 | Active-low reset; straps are captured while it is low |
| bpDisableStrap | input | 1 | 1 = back pressure off (sampled in reset) |
| cfgThreshold | input | USED_W | Congestion threshold (sampled in reset) |
| queueUsed | input | USED_W | Output-queue entries in use |
| freeAvail | input | 1 | 1 = at least one free buffer |
| carrierSense | input | 1 | Receive carrier of the input port |
| fullDuplex | input | 1 | 1 = port runs full duplex |
| jamReq | output | 1 | Request to send jam and force a collision |
| dropFlag | output | 1 | Current frame must be discarded |

## Verification
The assertions assume that `carrierSense` is low during reset and in the cycle that follows. Under that assumption, any rising `jamReq` can be traced back to a fresh carrier edge seen in half duplex. They also assume that `fullDuplex` and the straps do not toggle faster than once per clock cycle. The stimulus drives every input on the falling clock edge and holds carrier low across every reset. It then sweeps the queue count across the full range for a spread of thresholds, so both sides of the equality boundary are covered.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef struct packed {
    logic loadCnt;
    logic runCnt;
  } bpStrobe_t;
endpackage

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int USED_W  = 5,
  parameter int JAM_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bpDisableStrap,
  input  logic [USED_W-1:0] cfgThreshold,
  input  logic [USED_W-1:0] queueUsed,
  input  logic              carrierSense,
  input  bpStrobe_t         strobe,
  output logic              crsRise,
  output logic              congested,
  output logic              cntDone,
  output logic              bpDisabled
);
  localparam int CNT_W = $clog2(JAM_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(JAM_LEN - 1);

  logic [USED_W-1:0] thrQ;
  logic              disQ;
  logic              crsQ;
  logic [CNT_W-1:0]  jamCnt;

  // configuration captured only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thrQ <= cfgThreshold;
      disQ <= bpDisableStrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crsQ   <= 1'b0;
      jamCnt <= '0;
    end else begin
      crsQ <= carrierSense;
      if (strobe.loadCnt)
        jamCnt <= LOAD_VAL;
      else if (strobe.runCnt && jamCnt != '0)
        jamCnt <= jamCnt - 1'b1;
    end
  end

  assign crsRise    = carrierSense && !crsQ;
  assign congested  = (queueUsed >= thrQ);
  assign cntDone    = (jamCnt == '0);
  assign bpDisabled = disQ;
endmodule

// File: rtl/bp_control.sv
module bp_control
  import bp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      crsRise,
  input  logic      congested,
  input  logic      cntDone,
  input  logic      bpDisabled,
  input  logic      carrierSense,
  input  logic      fullDuplex,
  input  logic      freeAvail,
  output bpStrobe_t strobe,
  output logic      jamOn,
  output logic      dropOn
);
  typedef enum logic {S_IDLE, S_JAM} jamState_t;
  jamState_t state, stateNxt;
  logic      dropNxt;
  logic      startJam;

  assign startJam = crsRise && congested && !bpDisabled && !fullDuplex;

  always_comb begin
    stateNxt       = state;
    strobe.loadCnt = 1'b0;
    strobe.runCnt  = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (startJam) begin
          stateNxt       = S_JAM;
          strobe.loadCnt = 1'b1;
        end
      end
      S_JAM: begin
        strobe.runCnt = 1'b1;
        if (!carrierSense || fullDuplex || cntDone) stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_comb begin
    dropNxt = dropOn;
    if (!carrierSense)
      dropNxt = 1'b0;
    else if (crsRise && bpDisabled && !freeAvail)
      dropNxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      dropOn <= 1'b0;
    end else begin
      state  <= stateNxt;
      dropOn <= dropNxt;
    end
  end

  assign jamOn = (state == S_JAM);
endmodule

// File: rtl/bp_ctrl.sv
module bp_ctrl
  import bp_pkg::*;
#(
  parameter int USED_W  = 5,
  parameter int JAM_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bpDisableStrap,
  input  logic [USED_W-1:0] cfgThreshold,
  input  logic [USED_W-1:0] queueUsed,
  input  logic              freeAvail,
  input  logic              carrierSense,
  input  logic              fullDuplex,
  output logic              jamReq,
  output logic              dropFlag
);
  bpStrobe_t strobe;
  logic crsRise, congested, cntDone, bpDisabled;

  bp_datapath #(.USED_W(USED_W), .JAM_LEN(JAM_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .bpDisableStrap(bpDisableStrap),
    .cfgThreshold(cfgThreshold), .queueUsed(queueUsed),
    .carrierSense(carrierSense), .strobe(strobe), .crsRise(crsRise),
    .congested(congested), .cntDone(cntDone), .bpDisabled(bpDisabled)
  );

  bp_control u_ctl (
    .clk(clk), .rst_n(rst_n), .crsRise(crsRise), .congested(congested),
    .cntDone(cntDone), .bpDisabled(bpDisabled), .carrierSense(carrierSense),
    .fullDuplex(fullDuplex), .freeAvail(freeAvail), .strobe(strobe),
    .jamOn(jamReq), .dropOn(dropFlag)
  );
endmodule

// File: rtl/bp_ctrl_checker.sv
module bp_ctrl_checker #(
  parameter int JAM_LEN = 32
) (
  input logic clk,
  input logic rst_n,
  input logic carrierSense,
  input logic fullDuplex,
  input logic freeAvail,
  input logic jamReq,
  input logic dropFlag
);
  localparam int RUN_W = $clog2(JAM_LEN + 2);
  logic [RUN_W-1:0] jamRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) jamRun <= '0;
    else if (jamReq && jamRun <= RUN_W'(JAM_LEN)) jamRun <= jamRun + 1'b1;
    else if (!jamReq) jamRun <= '0;
  end

  AST_JAM_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jamReq) |-> $past(carrierSense) && !$past(carrierSense, 2) && !$past(fullDuplex)); // R2
  AST_JAM_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    jamRun <= RUN_W'(JAM_LEN)); // R3
  AST_JAM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !carrierSense |=> !jamReq); // R5
  AST_FD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fullDuplex && $past(fullDuplex) |-> !jamReq); // R6
  AST_DROP_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dropFlag) |-> $past(carrierSense) && !$past(freeAvail)); // R8
  AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(jamReq && dropFlag)); // R9
endmodule

bind bp_ctrl bp_ctrl_checker #(.JAM_LEN(JAM_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .carrierSense(carrierSense),
  .fullDuplex(fullDuplex), .freeAvail(freeAvail),
  .jamReq(jamReq), .dropFlag(dropFlag)
);

// File: tb/bp_ctrl_bench.sv
module bp_ctrl_bench;
  localparam int USED_W  = 5;
  localparam int JAM_LEN = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bpDisableStrap = 1'b0;
  logic [USED_W-1:0] cfgThreshold = '0;
  logic [USED_W-1:0] queueUsed = '0;
  logic freeAvail = 1'b1;
  logic carrierSense = 1'b0;
  logic fullDuplex = 1'b0;
  logic jamReq, dropFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bp_ctrl #(.USED_W(USED_W), .JAM_LEN(JAM_LEN)) u_bp_ctrl (
    .clk(clk), .rst_n(rst_n), .bpDisableStrap(bpDisableStrap),
    .cfgThreshold(cfgThreshold), .queueUsed(queueUsed), .freeAvail(freeAvail),
    .carrierSense(carrierSense), .fullDuplex(fullDuplex),
    .jamReq(jamReq), .dropFlag(dropFlag)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic dis, input logic [USED_W-1:0] thr);
    @(negedge clk);
    rst_n = 1'b0; carrierSense = 1'b0; bpDisableStrap = dis; cfgThreshold = thr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start_frame(input logic [USED_W-1:0] used);
    @(negedge clk);
    queueUsed = used; carrierSense = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic end_frame();
    @(negedge clk);
    carrierSense = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int thrList[6] = '{0, 1, 7, 15, 30, 31};
    int run;
    // R1 reset state
    do_reset(1'b0, 5'd4);
    check("R1 jam in reset", jamReq, 1'b0);
    check("R1 drop in reset", dropFlag, 1'b0);
    tick();
    check("R1 jam after reset", jamReq, 1'b0);
    check("R1 drop after reset", dropFlag, 1'b0);

    // R2 sweep of threshold against queue usage
    foreach (thrList[i]) begin
      do_reset(1'b0, USED_W'(thrList[i]));
      for (int u = 0; u < (1 << USED_W); u++) begin
        start_frame(USED_W'(u));
        check("R2 jam on frame start", jamReq, (u >= thrList[i]));
        end_frame();
        check("R5 jam released", jamReq, 1'b0);
        tick();
      end
    end

    // R3, R4 full length then no second jam in the same frame
    do_reset(1'b0, 5'd4);
    start_frame(5'd10);
    run = 0;
    while (jamReq === 1'b1 && run < JAM_LEN + 4) begin
      run++;
      tick();
    end
    checks++;
    if (run != JAM_LEN) begin
      errors++;
      $display("FAIL R3: actual %0d expected %0d jam cycles", run, JAM_LEN);
    end
    @(negedge clk) queueUsed = 5'd31;
    for (int k = 0; k < 6; k++) begin
      tick();
      check("R4 no second jam", jamReq, 1'b0);
    end
    end_frame();

    // R5 early release
    start_frame(5'd10);
    check("R5 jam up", jamReq, 1'b1);
    tick(); tick();
    end_frame();
    check("R5 released on carrier loss", jamReq, 1'b0);
    tick();

    // R6 full duplex
    @(negedge clk) fullDuplex = 1'b1;
    start_frame(5'd20);
    check("R6 no jam in full duplex", jamReq, 1'b0);
    tick();
    check("R6 no jam in full duplex later", jamReq, 1'b0);
    end_frame();
    @(negedge clk) fullDuplex = 1'b0;
    start_frame(5'd20);
    check("R6 jam half duplex", jamReq, 1'b1);
    @(negedge clk) fullDuplex = 1'b1;
    tick();
    check("R6 jam cut by full duplex", jamReq, 1'b0);
    end_frame();
    @(negedge clk) fullDuplex = 1'b0;

    // R9 enabled mode never drops
    @(negedge clk) freeAvail = 1'b0;
    start_frame(5'd1);
    check("R9 no drop when enabled", dropFlag, 1'b0);
    end_frame();
    @(negedge clk) freeAvail = 1'b1;

    // R10 threshold latched only during reset
    do_reset(1'b0, 5'd10);
    @(negedge clk) cfgThreshold = 5'd0;
    start_frame(5'd5);
    check("R10 threshold unchanged", jamReq, 1'b0);
    end_frame();
    start_frame(5'd10);
    check("R10 equality still congested", jamReq, 1'b1);
    end_frame();

    // R7, R8, R9 disabled mode
    do_reset(1'b1, 5'd0);
    for (int u = 0; u < (1 << USED_W); u += 5) begin
      start_frame(USED_W'(u));
      check("R7 no jam when disabled", jamReq, 1'b0);
      check("R9 no drop with free buffer", dropFlag, 1'b0);
      end_frame();
    end
    @(negedge clk) freeAvail = 1'b0;
    start_frame(5'd31);
    check("R8 drop set", dropFlag, 1'b1);
    check("R7 no jam when disabled", jamReq, 1'b0);
    @(negedge clk) freeAvail = 1'b1;
    tick(); tick();
    check("R8 drop held", dropFlag, 1'b1);
    end_frame();
    check("R8 drop cleared", dropFlag, 1'b0);
    start_frame(5'd31);
    check("R9 no drop when free at start", dropFlag, 1'b0);
    end_frame();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule